// File: doc/BRIEF.md
# Shared PHY Power Sequencer with Lane Reference Count

This block arbitrates power requests from up to four lanes that share one physical-layer macro. Each lane sends single-cycle power-on and power-off requests. For each lane the block keeps an idle control bit, where 1 means the lane is parked. It also keeps one shared count of the lanes that are powered. The PHY reset is held asserted while no lane is powered.

When the count goes from zero to one, the block runs the bring-up sequence once for all lanes:
1. Release the PHY reset.
2. Request a PLL lock.
3. Wait for the lock status.
4. Issue two configuration writes.
5. Wait for the PLL output flag to drop.
6. Request a lock again.
7. Wait for the lock status once more.

Every wait samples the status when it starts and again every `POLL_CYC` cycles. A wait gives up once `TIMEOUT_CYC` cycles have passed. A failed wait puts the PHY back in reset, undoes the count and lane changes of the request, and raises an error pulse.

Requests are latched as pending bits. While the bring-up is busy, new requests wait. They are then served one per cycle, lowest lane index first.

Top module: `phy_lane_sequencer`

## Requirements
- R1: After reset, `phyRst` is 1, every `laneIdle` bit is 1, `pwrCount` is 0, `busy` is 0, and no strobe or pulse output is active.
- R2: A power-on for a lane whose `laneIdle` bit is 1 clears that bit and adds one to `pwrCount`. A power-off for a lane whose bit is 0 sets the bit and subtracts one. `pwrCount` always equals the number of 0 bits in `laneIdle`.
- R3: The bring-up runs only on a power-on that finds `pwrCount` at 0. Any other power-on completes with no `lockReq`, no `cfgWr` and no change to `phyRst`.
- R4: The bring-up issues, in this order:
  - release of `phyRst`;
  - a `lockReq` pulse;
  - a wait for `pllLocked`=1;
  - a `cfgWr` with `cfgAddr`=0x10 and `cfgData`=0x8;
  - a `cfgWr` with `cfgAddr`=0x12 and `cfgData`=0x8;
  - a wait for `pllOutFlag`=0;
  - a `lockReq` pulse;
  - a wait for `pllLocked`=1.

  No step starts before the wait in front of it is satisfied.
- R5: A wait samples its status condition in its first cycle and then every `POLL_CYC` cycles. It fails at the first sample that finds the condition false once `TIMEOUT_CYC` cycles have passed since the wait began.
- R6: When a wait fails, `phyRst` returns to 1, `pwrCount` is decremented, the requesting lane's `laneIdle` bit returns to 1, and `errPulse` is high for one cycle. No `reqDone` is given for that request.
- R7: A power-off asserts `phyRst` only when it brings `pwrCount` to 0. Otherwise `phyRst` stays 0.
- R8: `busy` is high from the cycle after the bring-up starts until it ends. Requests that arrive while `busy` is high are held. After the bring-up they are served one per cycle in ascending lane index, with a power-on served before a power-off of the same lane.
- R9: Each successful request gives `reqDone` one cycle high, with only the bit of the served lane set. It appears while `busy` is low.
- R10: A power-off for a lane whose `laneIdle` bit is already 1 is ignored. So is a power-on for a lane whose bit is already 0. Neither changes `pwrCount`, `laneIdle` or `phyRst`, and neither gives `reqDone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| laneOnReq | input | NLANES | Per-lane power-on request pulse |
| laneOffReq | input | NLANES | Per-lane power-off request pulse |
| pllLocked | input | 1 | PLL lock status |
| pllOutFlag | input | 1 | PLL output flag; the bring-up waits for it to read 0 |
| phyRst | output | 1 | PHY reset, 1 = asserted |
| lockReq | output | 1 | One-cycle PLL lock request |
| cfgWr | output | 1 | Configuration write strobe |
| cfgAddr | output | 6 | Configuration write address |
| cfgData | output | 4 | Configuration write data |
| laneIdle | output | NLANES | Per-lane idle control, 1 = parked |
| pwrCount | output | $clog2(NLANES+1) | Number of powered lanes |
| busy | output | 1 | Bring-up in progress |
| reqDone | output | NLANES | One-hot completion pulse |
| errPulse | output | 1 | One-cycle bring-up failure pulse |

## Verification
The bench holds the PLL status low, and later holds the output flag high, at different points of the bring-up. A sequencer that skips a wait would show a configuration write or a second lock request too early. It also checks that a second power-on triggers no new lock request; a design that re-runs the bring-up would reset a PHY that is already in use. Ignored requests (power-off of a parked lane, repeated power-on) are checked for leaving the count untouched, since an unguarded design would make the count wrap. A stuck lock status checks the rollback and the failure time, and requests queued during a bring-up must complete in lane order rather than arrival order.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOCK1,
    ST_WAIT1,
    ST_CFG1,
    ST_CFG2,
    ST_WAIT2,
    ST_LOCK2,
    ST_WAIT3
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrPendOn;
    logic clrPendOff;
    logic idleSet;
    logic idleClr;
    logic cntUp;
    logic cntDown;
    logic rstSet;
    logic rstClr;
    logic timerRestart;
  } dpCtl_t;

  localparam logic [5:0] CFG_ADDR_RATE = 6'h10;
  localparam logic [5:0] CFG_ADDR_REFCLK = 6'h12;
  localparam logic [3:0] CFG_DATA_RATE = 4'h8;
  localparam logic [3:0] CFG_DATA_REFCLK = 4'h8;

endpackage

// File: rtl/phy_seq_dp.sv
module phy_seq_dp
  import phy_seq_pkg::*;
#(
  parameter int NLANES = 4,
  parameter int POLL_CYC = 25000,
  parameter int TIMEOUT_CYC = 12500000,
  localparam int LW = (NLANES > 1) ? $clog2(NLANES) : 1,
  localparam int CW = $clog2(NLANES + 1),
  localparam int PW = $clog2(POLL_CYC + 1),
  localparam int TW = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NLANES-1:0] laneOnReq,
  input  logic [NLANES-1:0] laneOffReq,
  input  dpCtl_t            ctl,
  input  logic [LW-1:0]     selLane,
  output logic [NLANES-1:0] pendOn,
  output logic [NLANES-1:0] pendOff,
  output logic [NLANES-1:0] laneIdle,
  output logic [CW-1:0]     pwrCount,
  output logic              phyRst,
  output logic              pollDue,
  output logic              timedOut
);

  logic [NLANES-1:0] selMask;
  logic [PW-1:0]     pollCnt;
  logic [TW-1:0]     waitCnt;

  assign selMask  = NLANES'(1) << selLane;
  assign pollDue  = (pollCnt == '0);
  assign timedOut = (waitCnt == TW'(TIMEOUT_CYC));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendOn   <= '0;
      pendOff  <= '0;
      laneIdle <= '1;
      pwrCount <= '0;
      phyRst   <= 1'b1;
    end else begin
      pendOn  <= (pendOn & ~(ctl.clrPendOn ? selMask : '0)) | laneOnReq;
      pendOff <= (pendOff & ~(ctl.clrPendOff ? selMask : '0)) | laneOffReq;
      if (ctl.idleSet)      laneIdle <= laneIdle | selMask;
      else if (ctl.idleClr) laneIdle <= laneIdle & ~selMask;
      if (ctl.cntUp)        pwrCount <= pwrCount + 1'b1;
      else if (ctl.cntDown) pwrCount <= pwrCount - 1'b1;
      if (ctl.rstSet)       phyRst <= 1'b1;
      else if (ctl.rstClr)  phyRst <= 1'b0;
    end
  end

  // poll/timeout timers, restarted whenever no wait is active
  always_ff @(posedge clk) begin
    if (!rstN || ctl.timerRestart) begin
      pollCnt <= '0;
      waitCnt <= '0;
    end else begin
      pollCnt <= pollDue ? PW'(POLL_CYC - 1) : pollCnt - 1'b1;
      if (!timedOut) waitCnt <= waitCnt + 1'b1;
    end
  end

endmodule

// File: rtl/phy_seq_ctrl.sv
module phy_seq_ctrl
  import phy_seq_pkg::*;
#(
  parameter int NLANES = 4,
  localparam int LW = (NLANES > 1) ? $clog2(NLANES) : 1,
  localparam int CW = $clog2(NLANES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NLANES-1:0] pendOn,
  input  logic [NLANES-1:0] pendOff,
  input  logic [NLANES-1:0] laneIdle,
  input  logic [CW-1:0]     pwrCount,
  input  logic              pllLocked,
  input  logic              pllOutFlag,
  input  logic              pollDue,
  input  logic              timedOut,
  output dpCtl_t            ctl,
  output logic [LW-1:0]     selLane,
  output logic              busy,
  output logic              lockReq,
  output logic              cfgWr,
  output logic [5:0]        cfgAddr,
  output logic [3:0]        cfgData,
  output logic [NLANES-1:0] reqDone,
  output logic              errPulse
);

  seqState_t     state, nextState;
  logic [LW-1:0] curLane, pickLane;
  logic          anyPend, doneSet, errSet, waitCond, isWait;

  // lowest-index lane with anything pending
  always_comb begin
    pickLane = '0;
    anyPend  = 1'b0;
    for (int i = NLANES - 1; i >= 0; i--) begin
      if (pendOn[i] || pendOff[i]) begin
        pickLane = LW'(i);
        anyPend  = 1'b1;
      end
    end
  end

  assign selLane = (state == ST_IDLE) ? pickLane : curLane;
  assign busy    = (state != ST_IDLE);
  assign lockReq = (state == ST_LOCK1) || (state == ST_LOCK2);
  assign cfgWr   = (state == ST_CFG1) || (state == ST_CFG2);
  assign cfgAddr = (state == ST_CFG2) ? CFG_ADDR_REFCLK : (state == ST_CFG1) ? CFG_ADDR_RATE : '0;
  assign cfgData = (state == ST_CFG2) ? CFG_DATA_REFCLK : (state == ST_CFG1) ? CFG_DATA_RATE : '0;
  assign isWait  = (state == ST_WAIT1) || (state == ST_WAIT2) || (state == ST_WAIT3);
  assign waitCond = (state == ST_WAIT2) ? !pllOutFlag : pllLocked;

  always_comb begin
    nextState = state;
    ctl = '0;
    ctl.timerRestart = !isWait;
    doneSet = 1'b0;
    errSet  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (anyPend) begin
          if (pendOn[pickLane]) begin
            ctl.clrPendOn = 1'b1;
            if (laneIdle[pickLane]) begin
              ctl.idleClr = 1'b1;
              ctl.cntUp   = 1'b1;
              if (pwrCount == '0) begin
                ctl.rstClr = 1'b1;
                nextState  = ST_LOCK1;
              end else begin
                doneSet = 1'b1;
              end
            end
          end else begin
            ctl.clrPendOff = 1'b1;
            if (!laneIdle[pickLane]) begin
              ctl.idleSet = 1'b1;
              ctl.cntDown = 1'b1;
              ctl.rstSet  = (pwrCount == CW'(1));
              doneSet     = 1'b1;
            end
          end
        end
      end
      ST_LOCK1: nextState = ST_WAIT1;
      ST_CFG1:  nextState = ST_CFG2;
      ST_CFG2:  nextState = ST_WAIT2;
      ST_LOCK2: nextState = ST_WAIT3;
      default: begin
        if (pollDue) begin
          if (waitCond) begin
            case (state)
              ST_WAIT1: nextState = ST_CFG1;
              ST_WAIT2: nextState = ST_LOCK2;
              default: begin
                nextState = ST_IDLE;
                doneSet   = 1'b1;
              end
            endcase
          end else if (timedOut) begin
            ctl.rstSet  = 1'b1;
            ctl.cntDown = 1'b1;
            ctl.idleSet = 1'b1;
            errSet      = 1'b1;
            nextState   = ST_IDLE;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      curLane  <= '0;
      reqDone  <= '0;
      errPulse <= 1'b0;
    end else begin
      state    <= nextState;
      if (state == ST_IDLE) curLane <= pickLane;
      reqDone  <= doneSet ? (NLANES'(1) << selLane) : '0;
      errPulse <= errSet;
    end
  end

endmodule

// File: rtl/phy_lane_sequencer.sv
module phy_lane_sequencer
  import phy_seq_pkg::*;
#(
  parameter int NLANES = 4,
  parameter int POLL_CYC = 25000,
  parameter int TIMEOUT_CYC = 12500000,
  localparam int LW = (NLANES > 1) ? $clog2(NLANES) : 1,
  localparam int CW = $clog2(NLANES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NLANES-1:0] laneOnReq,
  input  logic [NLANES-1:0] laneOffReq,
  input  logic              pllLocked,
  input  logic              pllOutFlag,
  output logic              phyRst,
  output logic              lockReq,
  output logic              cfgWr,
  output logic [5:0]        cfgAddr,
  output logic [3:0]        cfgData,
  output logic [NLANES-1:0] laneIdle,
  output logic [CW-1:0]     pwrCount,
  output logic              busy,
  output logic [NLANES-1:0] reqDone,
  output logic              errPulse
);

  dpCtl_t            ctl;
  logic [LW-1:0]     selLane;
  logic [NLANES-1:0] pendOn, pendOff;
  logic              pollDue, timedOut;

  phy_seq_dp #(.NLANES(NLANES), .POLL_CYC(POLL_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) uDp (
    .clk(clk), .rstN(rstN), .laneOnReq(laneOnReq), .laneOffReq(laneOffReq),
    .ctl(ctl), .selLane(selLane), .pendOn(pendOn), .pendOff(pendOff),
    .laneIdle(laneIdle), .pwrCount(pwrCount), .phyRst(phyRst),
    .pollDue(pollDue), .timedOut(timedOut)
  );

  phy_seq_ctrl #(.NLANES(NLANES)) uCtrl (
    .clk(clk), .rstN(rstN), .pendOn(pendOn), .pendOff(pendOff),
    .laneIdle(laneIdle), .pwrCount(pwrCount), .pllLocked(pllLocked),
    .pllOutFlag(pllOutFlag), .pollDue(pollDue), .timedOut(timedOut),
    .ctl(ctl), .selLane(selLane), .busy(busy), .lockReq(lockReq),
    .cfgWr(cfgWr), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .reqDone(reqDone), .errPulse(errPulse)
  );

endmodule

// File: rtl/phy_seq_checker.sv
module phy_seq_checker #(
  parameter int NLANES = 4,
  localparam int CW = $clog2(NLANES + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              phyRst,
  input logic              lockReq,
  input logic              cfgWr,
  input logic [NLANES-1:0] laneIdle,
  input logic [CW-1:0]     pwrCount,
  input logic              busy,
  input logic [NLANES-1:0] reqDone,
  input logic              errPulse
);

  a_r2_count_matches_lanes: assert property (@(posedge clk) disable iff (!rstN)
    pwrCount == CW'($countones(~laneIdle)));

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pwrCount) |-> (pwrCount == $past(pwrCount) + 1'b1) || (pwrCount + 1'b1 == $past(pwrCount)));

  a_r3_strobes_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    (lockReq || cfgWr) |-> busy);

  a_r7_reset_when_unpowered: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && pwrCount == '0) |-> phyRst);

  a_r6_error_rolls_back: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> (phyRst && !busy && reqDone == '0));

  a_r9_done_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(reqDone));

  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    (reqDone != '0) |-> !busy);

endmodule

bind phy_lane_sequencer phy_seq_checker #(.NLANES(NLANES)) uChk (
  .clk(clk), .rstN(rstN), .phyRst(phyRst), .lockReq(lockReq), .cfgWr(cfgWr),
  .laneIdle(laneIdle), .pwrCount(pwrCount), .busy(busy), .reqDone(reqDone),
  .errPulse(errPulse)
);

// File: tb/phy_lane_sequencer_test.sv
module phy_lane_sequencer_test;

  localparam int NL = 4;
  localparam int POLL = 4;
  localparam int TMO = 40;

  logic clk = 1'b0, rstN = 1'b0;
  logic [NL-1:0] laneOnReq = '0, laneOffReq = '0;
  logic pllLocked = 1'b0, pllOutFlag = 1'b1;
  logic phyRst, lockReq, cfgWr, busy, errPulse;
  logic [5:0] cfgAddr;
  logic [3:0] cfgData;
  logic [NL-1:0] laneIdle, reqDone;
  logic [2:0] pwrCount;

  int errors = 0, checks = 0;
  int cyc = 0, evN = 0, doneN = 0, errN = 0, busyN = 0;
  int lastLockCyc = 0, errCyc = 0;
  int evLog[0:15];
  int doneLog[0:15];

  always #4 clk = ~clk;

  phy_lane_sequencer #(.NLANES(NL), .POLL_CYC(POLL), .TIMEOUT_CYC(TMO)) uut (
    .clk(clk), .rstN(rstN), .laneOnReq(laneOnReq), .laneOffReq(laneOffReq),
    .pllLocked(pllLocked), .pllOutFlag(pllOutFlag), .phyRst(phyRst),
    .lockReq(lockReq), .cfgWr(cfgWr), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .laneIdle(laneIdle), .pwrCount(pwrCount), .busy(busy), .reqDone(reqDone),
    .errPulse(errPulse)
  );

  // monitor: 1 = lock request, 2 = cfg 0x10/0x8, 3 = cfg 0x12/0x8, 9 = other cfg
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rstN) begin
      if (busy) busyN <= busyN + 1;
      if (lockReq && evN < 16) begin
        evLog[evN] <= 1;
        evN <= evN + 1;
        lastLockCyc <= cyc;
      end else if (cfgWr && evN < 16) begin
        evLog[evN] <= (cfgAddr == 6'h10 && cfgData == 4'h8) ? 2 :
                      (cfgAddr == 6'h12 && cfgData == 4'h8) ? 3 : 9;
        evN <= evN + 1;
      end
      if (reqDone != '0 && doneN < 16) begin
        doneLog[doneN] <= $clog2(reqDone);
        doneN <= doneN + 1;
      end
      if (errPulse) begin
        errN <= errN + 1;
        errCyc <= cyc;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic idleCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseOn(input int lane);
    @(negedge clk) laneOnReq = NL'(1) << lane;
    @(negedge clk) laneOnReq = '0;
  endtask

  task automatic pulseOff(input int lane);
    @(negedge clk) laneOffReq = NL'(1) << lane;
    @(negedge clk) laneOffReq = '0;
  endtask

  task automatic waitDone(input int target);
    for (int i = 0; i < 300 && doneN < target; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(phyRst == 1'b1, "R1 phyRst", phyRst, 1);
    chk(laneIdle == 4'hF, "R1 laneIdle", laneIdle, 15);
    chk(pwrCount == 0 && !busy, "R1 count/busy", pwrCount, 0);
    chk(!lockReq && !cfgWr && reqDone == 0 && !errPulse, "R1 strobes", reqDone, 0);
  endtask

  task automatic t_first_on();
    pllLocked = 1'b0;
    pllOutFlag = 1'b1;
    pulseOn(0);
    for (int i = 0; i < 20 && evN == 0; i++) @(negedge clk);
    chk(phyRst == 1'b0, "R4 reset released", phyRst, 0);
    idleCycles(10);
    chk(evN == 1, "R4 waits for lock before cfg", evN, 1);
    pllLocked = 1'b1;
    for (int i = 0; i < 40 && evN < 3; i++) @(negedge clk);
    idleCycles(10);
    chk(evN == 3, "R4 waits for output flag", evN, 3);
    pllOutFlag = 1'b0;
    waitDone(1);
    chk(evN == 4, "R4 event count", evN, 4);
    chk(evLog[0] == 1 && evLog[1] == 2 && evLog[2] == 3 && evLog[3] == 1,
        "R4 order", evLog[0] * 1000 + evLog[1] * 100 + evLog[2] * 10 + evLog[3], 1231);
    chk(doneN == 1 && doneLog[0] == 0, "R9 done lane0", doneLog[0], 0);
    chk(pwrCount == 1 && laneIdle == 4'b1110, "R2 after first on", laneIdle, 14);
    chk(!busy, "R8 busy ends", busy, 0);
  endtask

  task automatic t_second_on();
    int b0 = busyN;
    pulseOn(2);
    waitDone(2);
    idleCycles(2);
    chk(doneN == 2 && doneLog[1] == 2, "R9 done lane2", doneLog[1], 2);
    chk(evN == 4 && busyN == b0, "R3 no second bring-up", evN, 4);
    chk(phyRst == 1'b0, "R3 reset untouched", phyRst, 0);
    chk(pwrCount == 2 && laneIdle == 4'b1010, "R2 second on", laneIdle, 10);
  endtask

  task automatic t_ignored();
    pulseOn(2);
    idleCycles(4);
    chk(doneN == 2 && pwrCount == 2, "R10 repeated on ignored", pwrCount, 2);
    pulseOff(1);
    idleCycles(4);
    chk(doneN == 2 && pwrCount == 2, "R10 off unpowered count", pwrCount, 2);
    chk(laneIdle == 4'b1010 && phyRst == 1'b0, "R10 off unpowered state", laneIdle, 10);
  endtask

  task automatic t_off();
    pulseOff(0);
    waitDone(3);
    idleCycles(1);
    chk(pwrCount == 1 && laneIdle == 4'b1011, "R2 off lane0", laneIdle, 11);
    chk(phyRst == 1'b0, "R7 reset held off at count 1", phyRst, 0);
    pulseOff(2);
    waitDone(4);
    idleCycles(1);
    chk(pwrCount == 0 && laneIdle == 4'hF, "R2 off lane2", pwrCount, 0);
    chk(phyRst == 1'b1, "R7 reset at count 0", phyRst, 1);
  endtask

  task automatic t_timeout();
    int d0 = doneN;
    pllLocked = 1'b0;
    pllOutFlag = 1'b0;
    pulseOn(3);
    for (int i = 0; i < 200 && errN == 0; i++) @(negedge clk);
    idleCycles(1);
    chk(errN == 1, "R6 error pulse", errN, 1);
    chk(phyRst == 1'b1 && pwrCount == 0, "R6 rollback", pwrCount, 0);
    chk(laneIdle == 4'hF && doneN == d0, "R6 lane restored no done", laneIdle, 15);
    chk(errCyc - lastLockCyc >= TMO && errCyc - lastLockCyc <= TMO + POLL + 2,
        "R5 timeout window", errCyc - lastLockCyc, TMO + 2);
  endtask

  task automatic t_held_order();
    int d0 = doneN;
    pllLocked = 1'b0;
    pllOutFlag = 1'b0;
    pulseOn(1);
    idleCycles(3);
    pulseOn(3);
    pulseOn(0);
    idleCycles(5);
    chk(busy && laneIdle[0] && laneIdle[3], "R8 requests held while busy", laneIdle, 15);
    pllLocked = 1'b1;
    waitDone(d0 + 3);
    idleCycles(2);
    chk(doneN == d0 + 3, "R8 all served", doneN - d0, 3);
    chk(doneLog[d0] == 1 && doneLog[d0+1] == 0 && doneLog[d0+2] == 3, "R8 lane order",
        doneLog[d0] * 100 + doneLog[d0+1] * 10 + doneLog[d0+2], 103);
    chk(pwrCount == 3 && laneIdle == 4'b0100, "R2 three lanes on", laneIdle, 4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    idleCycles(3);
    t_reset();
    rstN = 1'b1;
    idleCycles(2);
    t_first_on();
    t_second_on();
    t_ignored();
    t_off();
    t_timeout();
    t_held_order();
    summary();
    $finish;
  end

endmodule